// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from a faster reference clock. Two counting stages sit in series. The first divides by a programmable integer from 1 to 16. The second divides its output by a programmable power of two, with an exponent from 0 to 15. The overall ratio N = (pre + 1) * 2^post sets the distance, in reference cycles, between consecutive serial clock edge points.

The block marks each edge point with a one-cycle tick. While a transfer is marked active, the serial clock level toggles on every tick, so one full serial clock period spans 2N reference cycles. When no transfer is active, or when the block is disabled, the serial clock rests at a programmable idle level. Software works out the two field values from a target rate. The divider fields are sampled only while enable is low. The counters stay cleared while enable is low, so the first interval after enable rises has its full length.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: While rst_ni is low, tick_o is 0 and sclk_o is 0.
- R2: With enable_i high, tick_o is high in the cycle that follows every N-th enabled clock edge, where N = (pre + 1) * 2^post.
- R3: When N > 1, tick_o is high for exactly one reference cycle per edge point.
- R4: Counting restarts from zero whenever enable_i is low. The first tick therefore follows the N-th rising edge after enable_i rises.
- R5: While enable_i is low, tick_o stays 0.
- R6: When enable_i or active_i is low at a clock edge, sclk_o takes the value of idle_pol_i after that edge.
- R7: When enable_i and active_i are both high at a clock edge, sclk_o inverts exactly at the edges where tick_o rises or stays high.
- R8: pre_i and post_i are captured only on clock edges with enable_i low. Changes made while enable_i is high do not affect the tick spacing until enable_i has been low for at least one edge.
- R9: pre = 0 and post = 0 give a divide by 1: tick_o is high in every cycle after the first enabled edge.
- R10: The largest linear divide, pre = 15 (divide by 16), chains correctly with a power-of-two stage. pre = 15 with post = 3 gives 128 cycles, and pre = 0 with post = 10 gives 1024 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Runs the dividers; low clears them and opens field capture |
| active_i | input | 1 | Transfer in progress; lets sclk_o toggle |
| pre_i | input | 4 | Linear divide field; divides by pre_i + 1 |
| post_i | input | 4 | Power-of-two exponent field; divides by 2^post_i |
| idle_pol_i | input | 1 | Level of sclk_o while idle |
| tick_o | output | 1 | One-cycle pulse at each serial clock edge point |
| sclk_o | output | 1 | Serial clock level |

## Verification
The ratio is tried with only the linear stage in use (pre = 1, post = 0), with only the exponent stage in use (pre = 0, post = 10), with both stages mixed (pre = 2, post = 2 and pre = 15, post = 3), and with the divide-by-1 corner. These cases show a fault in one stage apart from a fault in the other, and a mask off by one from a correct one. A run in which the fields change while enabled shows that the capture window is honoured. Runs with active_i low and with each idle level show that idle holding is kept apart from toggling on ticks.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;
  localparam int unsigned PRE_W  = 4;
  localparam int unsigned POST_W = 4;

  typedef struct packed {
    logic [PRE_W-1:0]  pre;
    logic [POST_W-1:0] post;
  } presc_cfg_t;
endpackage

// File: rtl/spi_presc_cfg_hold.sv
module spi_presc_cfg_hold
  import spi_presc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  presc_cfg_t cfg_i,
  output presc_cfg_t cfg_o
);
  presc_cfg_t cfg_q;

  // fields are frozen while the dividers run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cfg_q <= '0;
    else if (!enable_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/spi_presc_lin_stage.sv
module spi_presc_lin_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enable_i,
  input  logic [W-1:0] limit_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         at_limit;

  assign at_limit = (cnt_q == limit_i);
  assign wrap_o   = enable_i & at_limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!enable_i) cnt_q <= '0;
    else if (at_limit)  cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_presc_pow_stage.sv
module spi_presc_pow_stage #(
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             step_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             hit_o
);
  localparam int unsigned CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  // low exp_i bits all ones marks the 2^exp boundary
  assign mask  = ~({CNT_W{1'b1}} << exp_i);
  assign hit_o = step_i & ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!enable_i) cnt_q <= '0;
    else if (step_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_presc_sclk_gen.sv
module spi_presc_sclk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic active_i,
  input  logic idle_pol_i,
  input  logic edge_i,
  output logic tick_o,
  output logic sclk_o
);
  logic tick_q;
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      tick_q <= enable_i & edge_i;
      if (!enable_i || !active_i) sclk_q <= idle_pol_i;
      else if (edge_i)            sclk_q <= ~sclk_q;
    end
  end

  assign tick_o = tick_q;
  assign sclk_o = sclk_q;
endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
  import spi_presc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              active_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [POST_W-1:0] post_i,
  input  logic              idle_pol_i,
  output logic              tick_o,
  output logic              sclk_o
);
  presc_cfg_t cfg_in;
  presc_cfg_t cfg;
  logic       lin_wrap;
  logic       pow_hit;

  assign cfg_in.pre  = pre_i;
  assign cfg_in.post = post_i;

  spi_presc_cfg_hold u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .cfg_i    (cfg_in),
    .cfg_o    (cfg)
  );

  spi_presc_lin_stage #(.W(PRE_W)) u_lin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .limit_i  (cfg.pre),
    .wrap_o   (lin_wrap)
  );

  spi_presc_pow_stage #(.EXP_W(POST_W)) u_pow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .step_i   (lin_wrap),
    .exp_i    (cfg.post),
    .hit_o    (pow_hit)
  );

  spi_presc_sclk_gen u_sclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .active_i   (active_i),
    .idle_pol_i (idle_pol_i),
    .edge_i     (pow_hit),
    .tick_o     (tick_o),
    .sclk_o     (sclk_o)
  );
endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk #(
  parameter int unsigned PRE_W  = 4,
  parameter int unsigned POST_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              active_i,
  input logic [PRE_W-1:0]  pre_i,
  input logic [POST_W-1:0] post_i,
  input logic              idle_pol_i,
  input logic              tick_o,
  input logic              sclk_o
);
  localparam int unsigned NW = PRE_W + 1 + (1 << POST_W);

  logic [NW-1:0] n_q;
  logic [NW-1:0] gap_q;
  logic          exp_tick_q;

  // independent ratio model, captured from the ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q        <= NW'(1);
      gap_q      <= '0;
      exp_tick_q <= 1'b0;
    end else if (!enable_i) begin
      n_q        <= NW'((32'(pre_i) + 32'd1) << post_i);
      gap_q      <= '0;
      exp_tick_q <= 1'b0;
    end else if (gap_q + 1'b1 == n_q) begin
      gap_q      <= '0;
      exp_tick_q <= 1'b1;
    end else begin
      gap_q      <= gap_q + 1'b1;
      exp_tick_q <= 1'b0;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!tick_o && !sclk_o));

  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o == exp_tick_q);

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && n_q != NW'(1)) |=> !tick_o);

  a_r5_no_tick_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !tick_o);

  a_r6_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i || !active_i) |=> (sclk_o == $past(idle_pol_i)));

  a_r7_toggle_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && active_i) |=> (tick_o == (sclk_o != $past(sclk_o))));
endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk #(
  .PRE_W  (spi_presc_pkg::PRE_W),
  .POST_W (spi_presc_pkg::POST_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .active_i   (active_i),
  .pre_i      (pre_i),
  .post_i     (post_i),
  .idle_pol_i (idle_pol_i),
  .tick_o     (tick_o),
  .sclk_o     (sclk_o)
);

// File: tb/spi_sclk_prescaler_bench.sv
module spi_sclk_prescaler_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic       active_i = 1'b0;
  logic [3:0] pre_i = '0;
  logic [3:0] post_i = '0;
  logic       idle_pol_i = 1'b0;
  logic       tick_o;
  logic       sclk_o;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int exp_q[$];
  logic exp_sclk = 1'b0;
  logic done = 1'b0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  spi_sclk_prescaler u_spi_sclk_prescaler (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .active_i(active_i),
    .pre_i(pre_i), .post_i(post_i), .idle_pol_i(idle_pol_i),
    .tick_o(tick_o), .sclk_o(sclk_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // monitor: tick times against queue, sclk against its model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (tick_o) begin
        if (exp_q.size() == 0) check(1'b0, "R2/R5 unexpected tick", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(e == cyc, "R2/R4 tick time", cyc, e);
        end
      end
      if (!enable_i || !active_i) exp_sclk = idle_pol_i;
      else if (tick_o)           exp_sclk = ~exp_sclk;
      if (sclk_o != exp_sclk) check(1'b0, "R6/R7 sclk level", sclk_o, exp_sclk);
    end
  end

  // driver: one enabled run, expected tick cycles pushed to the queue
  task automatic run_case(input int pre, input int post, input int nticks,
                          input bit act, input bit pol, input bit scramble, input string req);
    int n;
    int c0;
    n = (pre + 1) << post;
    @(negedge clk_i); #1;
    enable_i = 1'b0; active_i = act; idle_pol_i = pol;
    pre_i = 4'(pre); post_i = 4'(post);
    repeat (2) @(negedge clk_i);
    #1;
    enable_i = 1'b1;
    c0 = cyc;
    for (int k = 1; k <= nticks; k++) exp_q.push_back(c0 + k * n);
    if (scramble) begin
      @(negedge clk_i); #1;
      pre_i = 4'd7; post_i = 4'd3;   // R8: must not alter spacing
    end
    while (cyc < c0 + nticks * n) @(negedge clk_i);
    #1;
    enable_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #5;
    check(tick_o == 1'b0 && sclk_o == 1'b0, "R1 reset outputs", {tick_o, sclk_o}, 0);
    repeat (3) @(negedge clk_i);
    check(tick_o == 1'b0 && sclk_o == 1'b0, "R1 reset held", {tick_o, sclk_o}, 0);
    #1 rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(tick_o == 1'b0, "R5 no tick while disabled", tick_o, 0);

    run_case(0, 0, 6, 1'b1, 1'b0, 1'b0, "R9 divide by one");
    run_case(1, 0, 5, 1'b1, 1'b1, 1'b0, "R2 linear only");
    run_case(2, 2, 4, 1'b1, 1'b0, 1'b0, "R2 mixed stages");
    run_case(1, 1, 5, 1'b1, 1'b0, 1'b1, "R8 fields frozen while enabled");
    run_case(7, 3, 2, 1'b1, 1'b1, 1'b0, "R8 new fields after disable");
    run_case(15, 3, 3, 1'b1, 1'b0, 1'b0, "R10 max linear with exponent");
    run_case(0, 10, 2, 1'b1, 1'b1, 1'b0, "R10 exponent only");
    run_case(3, 1, 4, 1'b0, 1'b1, 1'b0, "R6 ticks with transfer idle");
    run_case(4, 0, 3, 1'b1, 1'b0, 1'b0, "R4 restart after disable");

    // R6: idle level follows idle_pol_i while disabled
    @(negedge clk_i); #1 idle_pol_i = 1'b1;
    @(negedge clk_i);
    check(sclk_o == 1'b1, "R6 idle high", sclk_o, 1);
    #1 idle_pol_i = 1'b0;
    @(negedge clk_i);
    check(sclk_o == 1'b0, "R6 idle low", sclk_o, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule